// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully-associative store that sits next to a direct-mapped first-level cache. Every line that the first-level cache throws out is offered to it on an eviction port, with its line address, its data and a dirty flag. Lines that fight over the same direct-mapped slot therefore stay close by. The block adds associativity only for those lines and costs nothing on first-level hits.

When the first-level cache misses, its controller presents the line address on the lookup port before it asks the next level. All valid entries are compared against the full address in parallel, and the answer comes back in the same cycle. On a hit the line is handed back for the refill and leaves the buffer. On a miss the controller forwards the request outward. The line that the refill displaces normally arrives on the eviction port in the same cycle, so the two lines trade places. When the buffer is full and no entry is freed, the entry inserted longest ago makes room. If that entry is dirty, it is first pushed out on a write-back port, and the eviction waits until the write-back is taken.

The depth is a parameter and may be 4 or 8. The first-level cache must never offer a line that the buffer already holds. It must hold an eviction steady until the eviction is accepted.

Top module: `victim_buffer`

## Requirements
- R1: After reset the buffer is empty: every lookup misses, `wb_valid` is 0 and `ev_ready` is 1.
- R2: An eviction offered while the buffer holds fewer than DEPTH lines is accepted in that cycle (`ev_ready`=1). A later lookup of the same address hits and returns the stored data and dirty flag.
- R3: In the cycle `lk_valid` is 1, the full line address is compared against every valid entry. Exactly one of `lk_hit` and `lk_miss` is 1 in that cycle, and both are 0 when `lk_valid` is 0. An address that differs from a stored address in any single bit misses.
- R4: A lookup hit removes that entry at the next clock edge, so a repeated lookup of the same address misses.
- R5: If a lookup hits in the same cycle that an eviction is offered to a full buffer, the eviction is accepted without a write-back (`ev_ready`=1, `wb_valid`=0). The new line takes the freed place.
- R6: An eviction into a full buffer whose oldest entry is clean is accepted at once. The oldest entry is discarded and `wb_valid` stays 0.
- R7: An eviction into a full buffer whose oldest entry is dirty, with no lookup hit in that cycle, raises `wb_valid` with that entry's address and data. `ev_ready` then follows `wb_ready`, and the buffer contents do not change while `ev_ready` is 0.
- R8: Replacement order is insertion order. A newly accepted line is the youngest entry. Removing an entry by a lookup hit keeps the relative age of all the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An evicted line is offered |
| ev_ready | output | 1 | Eviction accepted at this edge |
| ev_addr | input | AW | Line address of the evicted line |
| ev_data | input | DW | Data of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| lk_valid | input | 1 | Lookup request for an L1 miss |
| lk_addr | input | AW | Line address looked up |
| lk_hit | output | 1 | Lookup found the line |
| lk_miss | output | 1 | Lookup did not find the line |
| lk_data | output | DW | Data of the hit line |
| lk_dirty | output | 1 | Dirty flag of the hit line |
| wb_valid | output | 1 | A displaced dirty line is offered outward |
| wb_ready | input | 1 | Next level takes the write-back |
| wb_addr | output | AW | Address of the write-back line |
| wb_data | output | DW | Data of the write-back line |

## Verification
A lookup hit and an eviction can fall in the same cycle. This is the swap, and it decides whether a full buffer must displace its oldest line. The bench provokes it on a full buffer whose oldest entry is dirty, both in directed steps and in a random phase that often pairs the two. A behavioural queue model then checks that the eviction is accepted without a write-back and that later hit, miss and write-back results follow the new age order. A lookup that hits the very entry waiting to be written back during a stall is covered by the random phase as well. The model expects the stall to end at once, with no write-back.

// File: rtl/vc_pkg.sv
package vc_pkg;
  // Why an entry leaves the store at the next edge
  typedef enum logic [1:0] {
    RM_NONE   = 2'd0,
    RM_TAKE   = 2'd1,  // returned to L1 on a lookup hit
    RM_OLDEST = 2'd2   // displaced to make room
  } rm_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic [DEPTH-1:0] ent_vld,
  input  logic [AW-1:0] ent_addr [DEPTH],
  input  logic [DW-1:0] ent_data [DEPTH],
  input  logic          ent_dirty [DEPTH],
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [DW-1:0] hit_data,
  output logic          hit_dirty
);
  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = lk_valid && ent_vld[i] && (ent_addr[i] == lk_addr);
  end

  // One-hot OR mux: at most one entry can match
  always_comb begin
    hit_idx   = '0;
    hit_data  = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        hit_idx   = hit_idx | IW'(i);
        hit_data  = hit_data | ent_data[i];
        hit_dirty = hit_dirty | ent_dirty[i];
      end
    end
  end

  assign hit = |match;

  // R3: no address is held twice, so a lookup matches one entry at most
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic ev_valid,
  input  logic full,
  input  logic take,
  input  logic oldest_dirty,
  input  logic wb_ready,
  output logic ev_ready,
  output logic wb_valid,
  output logic push,
  output rm_e  rm
);
  logic need_wb;

  always_comb begin
    // A hit frees a slot; otherwise a full store with a dirty head must drain
    need_wb  = full && !take && oldest_dirty;
    ev_ready = !need_wb || wb_ready;
    wb_valid = ev_valid && need_wb;
    push     = ev_valid && ev_ready;
    if (take)              rm = RM_TAKE;
    else if (push && full) rm = RM_OLDEST;
    else                   rm = RM_NONE;
  end
endmodule

// File: rtl/vc_store.sv
module vc_store
  import vc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rm_e           rm,
  input  logic [IW-1:0] rm_idx,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          push_dirty,
  output logic [DEPTH-1:0] ent_vld,
  output logic [AW-1:0] ent_addr [DEPTH],
  output logic [DW-1:0] ent_data [DEPTH],
  output logic          ent_dirty [DEPTH],
  output logic [CW-1:0] count,
  output logic          full
);
  // Slot 0 is always the oldest line; younger lines sit at higher slots
  logic [AW-1:0] addr_nx  [DEPTH];
  logic [DW-1:0] data_nx  [DEPTH];
  logic          dirty_nx [DEPTH];
  logic [CW-1:0] count_nx;
  logic [CW-1:0] cnt_mid;
  logic [IW-1:0] ridx;
  logic          rm_en;
  logic          upd;

  always_comb begin
    rm_en    = (rm != RM_NONE);
    ridx     = (rm == RM_TAKE) ? rm_idx : '0;
    cnt_mid  = count - CW'(rm_en);
    count_nx = cnt_mid + CW'(push);
    upd      = rm_en || push;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shift;
    assign shift = rm_en && (IW'(i) >= ridx);
    always_comb begin
      addr_nx[i]  = ent_addr[i];
      data_nx[i]  = ent_data[i];
      dirty_nx[i] = ent_dirty[i];
      if (push && (CW'(i) == cnt_mid)) begin
        addr_nx[i]  = push_addr;
        data_nx[i]  = push_data;
        dirty_nx[i] = push_dirty;
      end else if (shift) begin
        if (i < DEPTH - 1) begin
          addr_nx[i]  = ent_addr[(i < DEPTH - 1) ? i + 1 : i];
          data_nx[i]  = ent_data[(i < DEPTH - 1) ? i + 1 : i];
          dirty_nx[i] = ent_dirty[(i < DEPTH - 1) ? i + 1 : i];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr[i]  <= '0;
        ent_data[i]  <= '0;
        ent_dirty[i] <= 1'b0;
      end else if (upd) begin
        ent_addr[i]  <= addr_nx[i];
        ent_data[i]  <= data_nx[i];
        ent_dirty[i] <= dirty_nx[i];
      end
    end

    assign ent_vld[i] = (CW'(i) < count);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (upd) count <= count_nx;
  end

  assign full = (count == CW'(DEPTH));

  // R2: occupancy never exceeds the depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R4: an entry leaving without a push shrinks the store by one
  a_r4_take_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rm == RM_TAKE && !push) |=> (count == $past(count) - CW'(1)));
  // R6: the head is displaced only when the store is full
  a_r6_oldest_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rm == RM_OLDEST) |-> full);
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [AW-1:0] ev_addr,
  input  logic [DW-1:0] ev_data,
  input  logic          ev_dirty,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic          lk_miss,
  output logic [DW-1:0] lk_data,
  output logic          lk_dirty,
  output logic          wb_valid,
  input  logic          wb_ready,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] ent_vld;
  logic [AW-1:0] ent_addr  [DEPTH];
  logic [DW-1:0] ent_data  [DEPTH];
  logic          ent_dirty [DEPTH];
  logic [CW-1:0] count;
  logic          full;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic          push;
  rm_e           rm;

  vc_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data),
    .ent_dirty(ent_dirty),
    .hit(hit), .hit_idx(hit_idx), .hit_data(lk_data), .hit_dirty(lk_dirty)
  );

  vc_ctrl u_ctrl (
    .ev_valid(ev_valid), .full(full), .take(hit),
    .oldest_dirty(ent_dirty[0]), .wb_ready(wb_ready),
    .ev_ready(ev_ready), .wb_valid(wb_valid), .push(push), .rm(rm)
  );

  vc_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rm(rm), .rm_idx(hit_idx),
    .push(push), .push_addr(ev_addr), .push_data(ev_data),
    .push_dirty(ev_dirty),
    .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data),
    .ent_dirty(ent_dirty), .count(count), .full(full)
  );

  assign lk_hit  = hit;
  assign lk_miss = lk_valid && !hit;
  assign wb_addr = ent_addr[0];
  assign wb_data = ent_data[0];

  // R3: a lookup answers hit or miss, never both
  a_r3_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss));
  // R7: a stalled eviction leaves the contents untouched
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> ($stable(count) && $stable(wb_addr)));
  // R7: a write-back is only offered from a full buffer
  a_r7_wb_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (count == CW'(DEPTH)));
  // R5: a hit always lets an eviction in
  a_r5_swap_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && ev_valid) |-> (ev_ready && !wb_valid));
  // R2: a plain insertion below full grows the buffer
  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !lk_hit && !full) |=> (count == $past(count) + CW'(1)));
endmodule

// File: tb/victim_buffer_bench.sv
`timescale 1ns/1ps
module victim_buffer_bench;
  localparam int DEPTH = 4;
  localparam int AW    = 12;
  localparam int DW    = 32;

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          dy;
  } ent_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic          ev_ready;
  logic [AW-1:0] ev_addr = '0;
  logic [DW-1:0] ev_data = '0;
  logic          ev_dirty = 1'b0;
  logic          lk_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit, lk_miss, lk_dirty;
  logic [DW-1:0] lk_data;
  logic          wb_valid;
  logic          wb_ready = 1'b0;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;

  int   errors = 0;
  int   checks = 0;
  bit   done = 0;
  string cur = "R1";
  ent_t q[$];

  always #4 clk = ~clk;

  victim_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_victim_buffer (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
    .ev_data(ev_data), .ev_dirty(ev_dirty),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_data(lk_data), .lk_dirty(lk_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_data(wb_data)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dat(input logic [AW-1:0] a);
    return {a, 4'hA, a[7:0], a ^ 12'h5C3};
  endfunction

  function automatic int find(input logic [AW-1:0] a);
    foreach (q[i]) if (q[i].a == a) return i;
    return -1;
  endfunction

  // One cycle: drive after the falling edge, compare, then advance the model
  task automatic step(input bit ev_v, input logic [AW-1:0] ea, input bit edy,
                      input bit lk_v, input logic [AW-1:0] la, input bit wbr,
                      output bit acc);
    int  idx;
    bit  hit, full, need, evr, wbv;
    @(negedge clk);
    ev_valid = ev_v; ev_addr = ea; ev_data = dat(ea); ev_dirty = edy;
    lk_valid = lk_v; lk_addr = la; wb_ready = wbr;
    #1;
    idx  = lk_v ? find(la) : -1;
    hit  = (idx >= 0);
    full = (q.size() == DEPTH);
    need = full && !hit && q[0].dy;
    evr  = !need || wbr;
    wbv  = ev_v && need;
    chk("lk_hit", 64'(lk_hit), 64'(hit));
    chk("lk_miss", 64'(lk_miss), 64'(lk_v && !hit));
    if (hit) begin
      chk("lk_data", 64'(lk_data), 64'(q[idx].d));
      chk("lk_dirty", 64'(lk_dirty), 64'(q[idx].dy));
    end
    chk("ev_ready", 64'(ev_ready), 64'(evr));
    chk("wb_valid", 64'(wb_valid), 64'(wbv));
    if (wbv) begin
      chk("wb_addr", 64'(wb_addr), 64'(q[0].a));
      chk("wb_data", 64'(wb_data), 64'(q[0].d));
    end
    if (hit) q.delete(idx);
    if (ev_v && evr) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back('{a: ea, d: dat(ea), dy: edy});
    end
    acc = ev_v && evr;
  endtask

  task automatic ins(input logic [AW-1:0] a, input bit dy);
    bit acc;
    step(1, a, dy, 0, '0, 1, acc);
  endtask

  task automatic look(input logic [AW-1:0] a);
    bit acc;
    step(0, '0, 0, 1, a, 0, acc);
  endtask

  task automatic idle();
    bit acc;
    step(0, '0, 0, 0, '0, 0, acc);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit acc;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty after reset
    cur = "R1";
    look(12'h010); look(12'h000); idle();

    // R2: fill below depth and read back data and dirty flags
    cur = "R2";
    ins(12'h101, 1); ins(12'h102, 0); ins(12'h103, 1);
    look(12'h102);            // hit, removed
    ins(12'h102, 0);

    // R3: single-bit address differences miss; no lookup means no answer
    cur = "R3";
    look(12'h101 ^ 12'h800); look(12'h101 ^ 12'h001); idle();

    // R4: a hit removes the line
    cur = "R4";
    look(12'h103); look(12'h103);

    // R8: order of age; q = 101,102 -> fill, take middle, refill
    cur = "R8";
    ins(12'h104, 0); ins(12'h105, 1);   // 101d,102,104,105d full
    look(12'h102);                      // 101d,104,105d
    ins(12'h106, 0);                    // 101d,104,105d,106
    step(1, 12'h107, 0, 0, '0, 1, acc); // wb 101, then 104,105d,106,107

    // R6: full with clean oldest (104) is dropped silently
    cur = "R6";
    ins(12'h108, 1);                    // 105d,106,107,108d
    look(12'h104);                      // must miss

    // R7: dirty oldest (105) stalls while wb_ready is low
    cur = "R7";
    step(1, 12'h109, 0, 0, '0, 0, acc);
    step(1, 12'h109, 0, 0, '0, 0, acc);
    step(1, 12'h109, 0, 0, '0, 0, acc);
    step(1, 12'h109, 0, 0, '0, 1, acc); // drains 105: 106,107,108d,109
    look(12'h105);

    // R5: make head dirty, then swap on a full buffer with dirty head
    cur = "R5";
    look(12'h106); ins(12'h10A, 1);     // 107,108d,109,10Ad
    look(12'h107); ins(12'h10B, 0);     // 108d,109,10Ad,10B
    step(1, 12'h10C, 1, 1, 12'h109, 0, acc);
    step(1, 12'h10D, 0, 1, 12'h108, 0, acc);
    idle();

    // R8: random traffic with held stalls and frequent swaps
    cur = "R8";
    begin
      bit            pend = 0;
      logic [AW-1:0] pa = '0;
      bit            pdy = 0;
      for (int n = 0; n < 3000; n++) begin
        bit            lv;
        logic [AW-1:0] la;
        if (!pend && ($urandom_range(0, 2) != 0)) begin
          do pa = 12'h200 + AW'($urandom_range(0, 15)); while (find(pa) >= 0);
          pdy  = 1'($urandom_range(0, 1));
          pend = 1;
        end
        lv = ($urandom_range(0, 1) == 1);
        if (q.size() > 0 && $urandom_range(0, 2) != 0)
          la = q[$urandom_range(0, q.size() - 1)].a;
        else
          la = 12'h200 + AW'($urandom_range(0, 15));
        if (pend && la == pa) la = la ^ 12'h400;
        step(pend, pa, pdy, lv, la, 1'($urandom_range(0, 1)), acc);
        if (acc) pend = 0;
      end
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule